// File: doc/BRIEF.md
# Collision Backoff and Retry Controller

This block sits beside the serial transmit path of a half-duplex Ethernet MAC and decides what happens after a collision. While a frame is on the wire, it counts bit-time ticks. A collision makes it ask the jam generator for a jam. Once the jam ends, it makes one of two choices. It may wait a pseudo-random number of slot times and an inter-frame gap, then tell the transmit path to start the frame again. Otherwise it aborts the frame and asks for it to be flushed from the transmit FIFO.

A collision that arrives after the frame has exceeded the late-collision window is never retried. The block counts the collisions of the current frame and gives up when the count reaches a limit. It also honours a retry-disable control. In the optional enhanced backoff mode, the slot-time and gap counters stop while receive carrier is present.

The controller is a state machine with seven states. IDLE waits for `tx_active`. XMIT times the frame. JAM holds the jam request until `jam_done`. BACKOFF counts slot times. GAP counts the inter-frame gap. RETRY pulses `retry_go`. DROP pulses `abort_tx` and `flush_req`. The named transitions are:
- IDLE→XMIT when the frame starts.
- XMIT→IDLE when the frame ends cleanly.
- XMIT→JAM on a collision.
- JAM→BACKOFF or JAM→DROP when the jam ends.
- BACKOFF→GAP when the slot count reaches zero.
- GAP→RETRY when the gap expires.
- RETRY→IDLE and DROP→IDLE unconditionally.

Top module: `coll_retry_ctrl`

## Requirements
- R1: After reset all outputs are 0, `attempt_cnt` is 0 and the state is IDLE.
- R2: A collision sampled in XMIT raises `jam_req` on the next cycle and increments `attempt_cnt`. A collision outside XMIT has no effect on `jam_req` or `attempt_cnt`.
- R3: A collision is late when the number of `bit_tick` cycles counted in XMIT before the sampling edge exceeds LATE_BITS. A late collision sets the sticky `late_coll` flag. After `jam_done`, a late collision leads to `abort_tx` and `flush_req` for one cycle and never to `retry_go`.
- R4: Let J be the edge that samples `jam_done` for a retried frame, with `bit_tick` held high. `retry_go` is high for exactly one cycle, starting at edge J + 1 + IFG_BITS + r·SLOT_BITS. Here r is an integer with 0 ≤ r < 2^min(n, BACKOFF_CAP), and n is `attempt_cnt`.
- R5: When `enh_backoff_en` is 1, every cycle with `crs_rx` high during BACKOFF or GAP adds one cycle to the R4 delay. When `enh_backoff_en` is 0, `crs_rx` has no effect on the delay.
- R6: With `retry_dis` at 1, every collision ends in DROP (`abort_tx` and `flush_req` pulse), and `attempt_cnt` returns to 0.
- R7: The collision that brings `attempt_cnt` to MAX_ATTEMPTS ends in DROP. It sets the sticky `retry_err` flag, and `attempt_cnt` returns to 0. `attempt_cnt` never exceeds MAX_ATTEMPTS.
- R8: A frame that leaves XMIT through `tx_active` falling with no collision clears `attempt_cnt` on the next cycle.
- R9: `jam_req`, `retry_go`, `abort_tx` and `backoff_busy` are never high together, and `retry_go` is never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| tx_active | input | 1 | Transmit path is sending the frame |
| coll_det | input | 1 | Collision detected on the medium |
| crs_rx | input | 1 | Receive carrier sense |
| jam_done | input | 1 | Jam sequence has finished |
| enh_backoff_en | input | 1 | Pause backoff and gap counting while carrier is present |
| retry_dis | input | 1 | Never retransmit after a collision |
| jam_req | output | 1 | Request the jam sequence (high in JAM) |
| retry_go | output | 1 | One-cycle pulse: restart the frame |
| abort_tx | output | 1 | One-cycle pulse: frame abandoned |
| flush_req | output | 1 | One-cycle pulse: discard frame from the FIFO |
| backoff_busy | output | 1 | High in BACKOFF and GAP |
| late_coll | output | 1 | Sticky late-collision flag |
| retry_err | output | 1 | Sticky retry-limit flag |
| attempt_cnt | output | $clog2(MAX_ATTEMPTS+1) | Collisions seen for the current frame |

## Verification
The bound checker watches several properties on every cycle:
- A collision in XMIT leads to JAM.
- A late collision, or a set retry-disable, leads to an abort.
- The sticky flags never fall.
- The counter stays within its limit and is cleared by a clean frame end.
- The slot counter is frozen while the enhanced mode sees carrier.
- The outputs are mutually exclusive.

Other behaviour can only be shown by the bench scenarios:
- The late-collision boundary, one tick either side of the window.
- The exact retry delay and the bound on the random slot count for each attempt.
- The extra delay that carrier adds in enhanced mode, and its absence in normal mode.
- The sixteen-collision give-up.

// File: rtl/coll_pkg.sv
package coll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XMIT,
        ST_JAM,
        ST_BACKOFF,
        ST_GAP,
        ST_RETRY,
        ST_DROP
    } coll_state_e;
endpackage

// File: rtl/coll_lfsr.sv
module coll_lfsr #(
    parameter int                 W     = 16,
    parameter int                 OUT_W = 10,
    parameter logic [W-1:0]       TAPS  = 16'hB400,
    parameter logic [W-1:0]       SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= (q >> 1) ^ (q[0] ? TAPS : '0);
    end

    assign rnd = q[OUT_W-1:0];
endmodule

// File: rtl/coll_frame_age.sv
module coll_frame_age #(
    parameter int LATE_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cnt_en,
    output logic is_late
);
    localparam int AW = $clog2(LATE_BITS + 2);
    localparam logic [AW-1:0] SAT = AW'(LATE_BITS + 1);

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)              age <= '0;
        else if (cnt_en && age != SAT)  age <= age + 1'b1;
    end

    assign is_late = (age > AW'(LATE_BITS));
endmodule

// File: rtl/coll_slot_timer.sv
module coll_slot_timer #(
    parameter int SLOT_BITS = 512,
    parameter int RW        = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [RW-1:0]                 load_val,
    input  logic                          run,
    input  logic                          tick,
    input  logic                          hold,
    output logic                          done,
    output logic [RW-1:0]                 slots_left,
    output logic [$clog2(SLOT_BITS)-1:0]  frac
);
    localparam int FW = $clog2(SLOT_BITS);
    localparam logic [FW-1:0] FRAC_LAST = FW'(SLOT_BITS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_left <= '0;
            frac       <= '0;
        end else if (load) begin
            slots_left <= load_val;
            frac       <= '0;
        end else if (run && tick && !hold && slots_left != '0) begin
            if (frac == FRAC_LAST) begin
                frac       <= '0;
                slots_left <= slots_left - 1'b1;
            end else begin
                frac <= frac + 1'b1;
            end
        end
    end

    assign done = (slots_left == '0);
endmodule

// File: rtl/coll_retry_ctrl.sv
module coll_retry_ctrl
    import coll_pkg::*;
#(
    parameter int           SLOT_BITS    = 512,
    parameter int           LATE_BITS    = 512,
    parameter int           IFG_BITS     = 96,
    parameter int           MAX_ATTEMPTS = 16,
    parameter int           BACKOFF_CAP  = 10,
    parameter int           LFSR_W       = 16,
    parameter logic [15:0]  LFSR_TAPS    = 16'hB400,
    parameter logic [15:0]  LFSR_SEED    = 16'hACE1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bit_tick,
    input  logic                                tx_active,
    input  logic                                coll_det,
    input  logic                                crs_rx,
    input  logic                                jam_done,
    input  logic                                enh_backoff_en,
    input  logic                                retry_dis,
    output logic                                jam_req,
    output logic                                retry_go,
    output logic                                abort_tx,
    output logic                                flush_req,
    output logic                                backoff_busy,
    output logic                                late_coll,
    output logic                                retry_err,
    output logic [$clog2(MAX_ATTEMPTS+1)-1:0]   attempt_cnt
);
    localparam int CW = $clog2(MAX_ATTEMPTS + 1);
    localparam int RW = BACKOFF_CAP;
    localparam int FW = $clog2(SLOT_BITS);
    localparam int IW = $clog2(IFG_BITS);
    localparam logic [IW-1:0] GAP_LAST = IW'(IFG_BITS - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MAX_ATTEMPTS);

    coll_state_e state_q, state_d;

    logic           hold;
    logic           in_xmit, coll_hit;
    logic           age_late;
    logic [RW-1:0]  rnd;
    logic [CW-1:0]  cnt_inc;
    int             k_sel;
    logic [RW:0]    mask_w;
    logic [RW-1:0]  r_q;
    logic           late_cur_q, give_up_q;
    logic           abort_sel, tmr_load, tmr_done;
    logic [RW-1:0]  tmr_slots;
    logic [FW-1:0]  tmr_frac;
    logic [IW-1:0]  gap_q;
    logic           gap_last;

    assign hold     = enh_backoff_en & crs_rx;
    assign in_xmit  = (state_q == ST_XMIT);
    assign coll_hit = in_xmit & coll_det;

    coll_frame_age #(.LATE_BITS(LATE_BITS)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_IDLE),
        .cnt_en  (in_xmit & bit_tick),
        .is_late (age_late)
    );

    coll_lfsr #(.W(LFSR_W), .OUT_W(RW), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    coll_slot_timer #(.SLOT_BITS(SLOT_BITS), .RW(RW)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .load_val   (r_q),
        .run        (state_q == ST_BACKOFF),
        .tick       (bit_tick),
        .hold       (hold),
        .done       (tmr_done),
        .slots_left (tmr_slots),
        .frac       (tmr_frac)
    );

    // exponent of the backoff window: attempt number capped
    always_comb begin
        cnt_inc = attempt_cnt + 1'b1;
        k_sel   = (int'(cnt_inc) > BACKOFF_CAP) ? BACKOFF_CAP : int'(cnt_inc);
        mask_w  = ((RW+1)'(1) << k_sel) - 1'b1;
    end

    assign abort_sel = late_cur_q | retry_dis | give_up_q;
    assign tmr_load  = (state_q == ST_JAM) & jam_done & ~abort_sel;
    assign gap_last  = (state_q == ST_GAP) & bit_tick & ~hold & (gap_q == GAP_LAST);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tx_active) state_d = ST_XMIT;
            ST_XMIT:    if (coll_det) state_d = ST_JAM;
                        else if (!tx_active) state_d = ST_IDLE;
            ST_JAM:     if (jam_done) state_d = abort_sel ? ST_DROP : ST_BACKOFF;
            ST_BACKOFF: if (tmr_done) state_d = ST_GAP;
            ST_GAP:     if (gap_last) state_d = ST_RETRY;
            ST_RETRY:   state_d = ST_IDLE;
            ST_DROP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // attempt bookkeeping, random draw and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attempt_cnt <= '0;
            late_cur_q  <= 1'b0;
            give_up_q   <= 1'b0;
            r_q         <= '0;
            late_coll   <= 1'b0;
            retry_err   <= 1'b0;
        end else begin
            if (coll_hit) begin
                attempt_cnt <= cnt_inc;
                late_cur_q  <= age_late;
                give_up_q   <= (cnt_inc >= CNT_MAX);
                r_q         <= rnd & mask_w[RW-1:0];
                if (age_late) late_coll <= 1'b1;
            end else if (in_xmit && !tx_active) begin
                attempt_cnt <= '0;
            end
            if (state_q == ST_JAM && jam_done && abort_sel) begin
                attempt_cnt <= '0;
                if (give_up_q) retry_err <= 1'b1;
            end
        end
    end

    // inter-frame gap counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (state_q != ST_GAP)
            gap_q <= '0;
        else if (bit_tick && !hold && !gap_last)
            gap_q <= gap_q + 1'b1;
    end

    // outputs
    always_comb begin
        jam_req      = (state_q == ST_JAM);
        retry_go     = (state_q == ST_RETRY);
        abort_tx     = (state_q == ST_DROP);
        flush_req    = (state_q == ST_DROP);
        backoff_busy = (state_q == ST_BACKOFF) || (state_q == ST_GAP);
    end
endmodule

// File: rtl/coll_retry_chk.sv
module coll_retry_chk
    import coll_pkg::*;
#(
    parameter int CW   = 5,
    parameter int MAXA = 16,
    parameter int RW   = 10,
    parameter int FW   = 9
) (
    input logic          clk,
    input logic          rst_n,
    input coll_state_e   state_q,
    input logic          coll_det,
    input logic          tx_active,
    input logic          jam_done,
    input logic          retry_dis,
    input logic          enh_backoff_en,
    input logic          crs_rx,
    input logic          jam_req,
    input logic          retry_go,
    input logic          abort_tx,
    input logic          flush_req,
    input logic          backoff_busy,
    input logic          late_coll,
    input logic          retry_err,
    input logic [CW-1:0] attempt_cnt,
    input logic          late_cur,
    input logic [RW-1:0] tmr_slots,
    input logic [FW-1:0] tmr_frac
);
    p_coll_to_jam_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XMIT && coll_det) |=> jam_req);

    p_idle_coll_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && coll_det && !tx_active) |=> !jam_req);

    p_late_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JAM && jam_done && late_cur) |=> (abort_tx && flush_req));

    p_late_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        late_coll |=> late_coll);

    p_carrier_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF && enh_backoff_en && crs_rx) |=> ($stable(tmr_slots) && $stable(tmr_frac)));

    p_disable_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JAM && jam_done && retry_dis) |=> abort_tx);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        attempt_cnt <= CW'(MAXA));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retry_err |=> retry_err);

    p_success_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XMIT && !coll_det && !tx_active) |=> (attempt_cnt == '0));

    p_excl_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jam_req, retry_go, abort_tx, backoff_busy}));

    p_retry_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retry_go |=> !retry_go);

    p_no_retry_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
        retry_go |-> !late_cur);
endmodule

bind coll_retry_ctrl coll_retry_chk #(
    .CW(CW), .MAXA(MAX_ATTEMPTS), .RW(RW), .FW(FW)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_q        (state_q),
    .coll_det       (coll_det),
    .tx_active      (tx_active),
    .jam_done       (jam_done),
    .retry_dis      (retry_dis),
    .enh_backoff_en (enh_backoff_en),
    .crs_rx         (crs_rx),
    .jam_req        (jam_req),
    .retry_go       (retry_go),
    .abort_tx       (abort_tx),
    .flush_req      (flush_req),
    .backoff_busy   (backoff_busy),
    .late_coll      (late_coll),
    .retry_err      (retry_err),
    .attempt_cnt    (attempt_cnt),
    .late_cur       (late_cur_q),
    .tmr_slots      (tmr_slots),
    .tmr_frac       (tmr_frac)
);

// File: tb/test_coll_retry_ctrl.sv
module test_coll_retry_ctrl;
    localparam int SLOT  = 8;
    localparam int LATE  = 64;
    localparam int IFG   = 12;
    localparam int MAXA  = 16;
    localparam int CAP   = 10;
    localparam int LIMIT = 20000;

    typedef struct packed {
        logic [15:0] k;      // cycles in XMIT before collision (age seen = k-1)
        logic        dis;
        logic        late;   // expected late classification
        logic        abort;  // expected DROP instead of retry
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'd10,  1'b0, 1'b0, 1'b0},
        '{16'd65,  1'b0, 1'b0, 1'b0},
        '{16'd66,  1'b0, 1'b1, 1'b1},
        '{16'd200, 1'b0, 1'b1, 1'b1},
        '{16'd10,  1'b1, 1'b0, 1'b1},
        '{16'd66,  1'b1, 1'b1, 1'b1},
        '{16'd2,   1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n, bit_tick, tx_active, coll_det, crs_rx, jam_done, enh_backoff_en, retry_dis;
    logic jam_req, retry_go, abort_tx, flush_req, backoff_busy, late_coll, retry_err;
    logic [4:0] attempt_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    coll_retry_ctrl #(
        .SLOT_BITS(SLOT), .LATE_BITS(LATE), .IFG_BITS(IFG),
        .MAX_ATTEMPTS(MAXA), .BACKOFF_CAP(CAP)
    ) i_coll_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_active(tx_active),
        .coll_det(coll_det), .crs_rx(crs_rx), .jam_done(jam_done),
        .enh_backoff_en(enh_backoff_en), .retry_dis(retry_dis),
        .jam_req(jam_req), .retry_go(retry_go), .abort_tx(abort_tx),
        .flush_req(flush_req), .backoff_busy(backoff_busy), .late_coll(late_coll),
        .retry_err(retry_err), .attempt_cnt(attempt_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_tick = 1'b1; tx_active = 1'b0; coll_det = 1'b0;
        crs_rx = 1'b0; jam_done = 1'b0; enh_backoff_en = 1'b0; retry_dis = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // start at a negedge in IDLE; ends at the negedge after the collision edge
    task automatic collide(input int k);
        tx_active = 1'b1;
        repeat (k) @(negedge clk);
        coll_det  = 1'b1;
        tx_active = 1'b0;
        @(negedge clk);
        coll_det  = 1'b0;
    endtask

    task automatic end_jam();
        jam_done = 1'b1;
        @(negedge clk);
        jam_done = 1'b0;
    endtask

    // measures edges from jam_done sample to retry_go; carrier for pz cycles
    task automatic wait_retry(input int pz, output int d);
        int c = 1;
        while (!retry_go && c < LIMIT) begin
            if (pz > 0 && c == 2) crs_rx = 1'b1;
            if (c == 2 + pz) crs_rx = 1'b0;
            @(negedge clk);
            c++;
        end
        crs_rx = 1'b0;
        d = c - 1;
        @(negedge clk);
        chk(retry_go == 1'b0, "R9 retry_go single cycle", int'(retry_go), 0);
    endtask

    task automatic check_delay(input int d, input int extra, input int n, input string req, output int r);
        int rem = d - 1 - IFG - extra;
        int kk  = (n > CAP) ? CAP : n;
        r = rem / SLOT;
        chk(rem >= 0 && (rem % SLOT) == 0 && r < (1 << kk), req, d, 1 + IFG + extra + r * SLOT);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int d, r, rmax;

        // R1 reset state
        rst_n = 1'b0; bit_tick = 1'b1; tx_active = 1'b0; coll_det = 1'b0;
        crs_rx = 1'b0; jam_done = 1'b0; enh_backoff_en = 1'b0; retry_dis = 1'b0;
        repeat (2) @(negedge clk);
        chk({jam_req, retry_go, abort_tx, flush_req, backoff_busy, late_coll, retry_err} == '0,
            "R1 outputs in reset", int'({jam_req, retry_go, abort_tx, flush_req, backoff_busy, late_coll, retry_err}), 0);
        do_reset();
        chk(attempt_cnt == 0, "R1 count after reset", int'(attempt_cnt), 0);

        // vector table: collision age, retry disable
        foreach (VECS[i]) begin
            do_reset();
            retry_dis = VECS[i].dis;
            collide(int'(VECS[i].k));
            chk(jam_req == 1'b1, "R2 jam after collision", int'(jam_req), 1);
            chk(attempt_cnt == 1, "R2 count increments", int'(attempt_cnt), 1);
            chk(late_coll == VECS[i].late, "R3 late classification", int'(late_coll), int'(VECS[i].late));
            end_jam();
            if (VECS[i].abort) begin
                chk(abort_tx && flush_req, "R3/R6 abort and flush", int'({abort_tx, flush_req}), 3);
                chk(attempt_cnt == 0, "R6 count cleared on abort", int'(attempt_cnt), 0);
                @(negedge clk);
                chk(!abort_tx && !retry_go, "R3 no retry after abort", int'({abort_tx, retry_go}), 0);
                repeat (30) @(negedge clk);
                chk(!retry_go && !backoff_busy, "R3 stays idle", int'({retry_go, backoff_busy}), 0);
            end else begin
                chk(backoff_busy == 1'b1, "R4 backoff entered", int'(backoff_busy), 1);
                wait_retry(0, d);
                check_delay(d, 0, 1, "R4 first retry delay", r);
            end
        end

        // R2 collision outside XMIT ignored
        do_reset();
        coll_det = 1'b1;
        @(negedge clk);
        coll_det = 1'b0;
        chk(!jam_req && attempt_cnt == 0, "R2 idle collision ignored", int'(jam_req), 0);

        // R8 clean frame after a retry clears the count
        do_reset();
        collide(5);
        end_jam();
        wait_retry(0, d);
        chk(attempt_cnt == 1, "R8 count held across retry", int'(attempt_cnt), 1);
        tx_active = 1'b1;
        repeat (20) @(negedge clk);
        tx_active = 1'b0;
        @(negedge clk);
        chk(attempt_cnt == 0, "R8 count cleared on success", int'(attempt_cnt), 0);

        // R5 enhanced mode: carrier stretches the wait by exactly its length
        do_reset();
        enh_backoff_en = 1'b1;
        collide(5);
        end_jam();
        wait_retry(5, d);
        check_delay(d, 5, 1, "R5 enhanced pause", r);

        // R5 normal mode: carrier ignored
        do_reset();
        collide(5);
        end_jam();
        wait_retry(5, d);
        check_delay(d, 0, 1, "R5 carrier ignored when disabled", r);

        // R7 sixteen collisions then give up; R4 window grows with attempt
        do_reset();
        rmax = 0;
        for (int n = 1; n <= MAXA; n++) begin
            collide(5);
            chk(attempt_cnt == n, "R7 attempt count", int'(attempt_cnt), n);
            end_jam();
            if (n < MAXA) begin
                wait_retry(0, d);
                check_delay(d, 0, n, "R4 retry window", r);
                if (r > rmax) rmax = r;
            end else begin
                chk(abort_tx && flush_req, "R7 give-up abort", int'({abort_tx, flush_req}), 3);
                chk(retry_err == 1'b1, "R7 retry error set", int'(retry_err), 1);
                chk(attempt_cnt == 0, "R7 count cleared", int'(attempt_cnt), 0);
                @(negedge clk);
                chk(retry_err == 1'b1 && !retry_go, "R7 sticky, no retry", int'(retry_err), 1);
            end
        end
        chk(rmax > 0, "R4 random slot count nonzero", rmax, 1);

        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule